// File: doc/BRIEF.md
# Soft-Decision Branch Metric Unit

This block sits at the front of a Viterbi decoder for a rate-1/2 convolutional code. On each trellis step it takes a pair of 3-bit soft symbols together with a valid strobe. For every possible noiseless output pair it returns the squared Euclidean distance between the received pair and that pair. The four registered metrics and a valid flag feed the add-compare-select array.

The received sample needs no run-time multiplier. Each soft value is a point on a scale running from 0 to 7. An ideal zero sits at 0 and an ideal one sits at 7, so a hard zero (000) and a hard one (111) land exactly on the ideal points. The distance is formed in its expanded form: the square of the sample, plus a precomputed square of the ideal point, minus twice their product. Because the ideal point is the constant 7, that product is a pair of shifts and a subtraction. The sample's own square comes from a table of eight entries built at elaboration. A per-symbol keep mask accompanies each pair. A symbol whose keep bit is clear is treated as absent and adds nothing to any metric. The all-ones mask means both symbols are present.

Top module: `soft_bmu`

## Requirements
- R1: For hypothesis h and kept symbols k, the metric equals the sum of (s_k - 7*b_k)^2. Here s_k is the unsigned 3-bit soft value and b_k is bit k of h, so ideal zero is 0 and ideal one is 7.
- R2: Symbol k is carried on soft_i bits [3k+2:3k], and bit k of a hypothesis index is the ideal bit for symbol k. The metric for hypothesis h is on metric_o bits [7h+6:7h].
- R3: Each metric is 7 bits wide and never exceeds 98, the distance of the pair (7,7) from hypothesis 0 and of (0,0) from hypothesis 3. The metric does not wrap.
- R4: keep_i bit k set means symbol k is present. A symbol with keep bit 0 contributes zero to every metric, and a mask of 00 yields four zero metrics.
- R5: out_valid is in_valid delayed by exactly one clock cycle.
- R6: While in_valid is low, the four metrics hold their previous values whatever soft_i and keep_i do.
- R7: While rst_n is low, out_valid is 0 and all metrics are 0, even if in_valid is high.
- R8: For a pair of hard values (each 000 or 111) with both symbols kept, exactly one metric is zero. It is the metric whose index matches the hard bits, and the others are 49 or 98.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A new symbol pair is present this cycle |
| soft_i | input | 6 | Two 3-bit soft symbols, symbol 0 in the low bits |
| keep_i | input | 2 | Per-symbol presence mask, 1 = present |
| out_valid | output | 1 | Metrics updated on the previous edge |
| metric_o | output | 28 | Four 7-bit metrics, hypothesis 0 in the low bits |

## Verification
The hardest situation to reach from the ports is a cycle in which in_valid is low while soft_i and keep_i change, so that a metric update would be wrong but invisible if the inputs happened to repeat. The driver places idle cycles with fresh, differing inputs between valid steps. The scoreboard expects the last metrics to be held in each of those cycles. A sweep over all 64 soft pairs, with the partial and empty masks and the two extreme pairs, reaches the peak metric and every absent-symbol case.

// File: rtl/sbmu_pkg.sv
package sbmu_pkg;

   // Square of the largest soft level for a given sample width.
   function automatic int unsigned peak_square(input int unsigned soft_w);
      return ((32'd1 << soft_w) - 32'd1) * ((32'd1 << soft_w) - 32'd1);
   endfunction

   // Bits needed to hold values 0 .. v.
   function automatic int unsigned bits_for(input int unsigned v);
      int unsigned n;
      n = 1;
      while ((32'd1 << n) <= v) n++;
      return n;
   endfunction

   // Width of a summed metric for nsym symbols of soft_w bits.
   function automatic int unsigned metric_bits(input int unsigned soft_w,
                                               input int unsigned nsym);
      return bits_for(nsym * peak_square(soft_w));
   endfunction

endpackage

// File: rtl/sbmu_sym_term.sv
// Per-symbol distance to the two ideal points (0 and the top level).
// No multiplier on the received sample: its square comes from an
// elaboration-built table and the cross term is formed with shifts.
module sbmu_sym_term #(
   parameter int unsigned SOFT_W = 3,
   parameter int unsigned TERM_W = 2 * SOFT_W
) (
   input  logic [SOFT_W-1:0] soft_i,
   input  logic              keep_i,
   output logic [TERM_W-1:0] dist_zero_o,
   output logic [TERM_W-1:0] dist_one_o
);
   localparam int unsigned LEVELS = 1 << SOFT_W;
   localparam int unsigned PEAK   = LEVELS - 1;
   localparam int unsigned EXT_W  = 2 * SOFT_W + 2;
   localparam logic [EXT_W-1:0] PEAK_SQ = EXT_W'(PEAK * PEAK);

   if (TERM_W < 2 * SOFT_W) begin : g_bad_term
      $error("sbmu_sym_term: TERM_W too narrow for a squared level");
   end

   logic [EXT_W-1:0] sq_tab [LEVELS];
   for (genvar gi = 0; gi < LEVELS; gi++) begin : g_sq
      assign sq_tab[gi] = EXT_W'(gi * gi);
   end

   logic [EXT_W-1:0] soft_ext;
   logic [EXT_W-1:0] sq_v;
   logic [EXT_W-1:0] cross_v;
   logic [EXT_W-1:0] one_v;

   always_comb begin
      soft_ext = EXT_W'(soft_i);
      sq_v     = sq_tab[soft_i];
      // 2 * s * (2^W - 1) = s * 2^(W+1) - 2s
      cross_v  = (soft_ext << (SOFT_W + 1)) - (soft_ext << 1);
      // s^2 + C^2 - 2sC, never negative
      one_v    = sq_v + PEAK_SQ - cross_v;
   end

   assign dist_zero_o = keep_i ? TERM_W'(sq_v)  : '0;
   assign dist_one_o  = keep_i ? TERM_W'(one_v) : '0;

endmodule

// File: rtl/sbmu_hyp_sum.sv
// Sums the per-symbol terms for each ideal output hypothesis.
module sbmu_hyp_sum #(
   parameter int unsigned NUM_SYM = 2,
   parameter int unsigned TERM_W  = 6,
   parameter int unsigned MW      = 7
) (
   input  logic [NUM_SYM-1:0][TERM_W-1:0]        dz_i,
   input  logic [NUM_SYM-1:0][TERM_W-1:0]        d1_i,
   output logic [(1<<NUM_SYM)-1:0][MW-1:0]       sum_o
);
   localparam int unsigned HYP = 1 << NUM_SYM;

   for (genvar h = 0; h < HYP; h++) begin : g_hyp
      localparam logic [NUM_SYM-1:0] HBITS = NUM_SYM'(h);
      logic [MW-1:0] acc;
      always_comb begin
         acc = '0;
         for (int k = 0; k < NUM_SYM; k++) begin
            acc = acc + (HBITS[k] ? MW'(d1_i[k]) : MW'(dz_i[k]));
         end
      end
      assign sum_o[h] = acc;
   end

endmodule

// File: rtl/soft_bmu.sv
module soft_bmu
   import sbmu_pkg::*;
#(
   parameter int unsigned SOFT_W  = 3,
   parameter int unsigned NUM_SYM = 2,
   parameter int unsigned MW      = metric_bits(SOFT_W, NUM_SYM)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              in_valid,
   input  logic [NUM_SYM*SOFT_W-1:0]         soft_i,
   input  logic [NUM_SYM-1:0]                keep_i,
   output logic                              out_valid,
   output logic [(1<<NUM_SYM)*MW-1:0]        metric_o
);
   localparam int unsigned HYP        = 1 << NUM_SYM;
   localparam int unsigned TERM_W     = 2 * SOFT_W;
   localparam int unsigned PEAK       = (1 << SOFT_W) - 1;
   localparam int unsigned MAX_METRIC = NUM_SYM * peak_square(SOFT_W);
   localparam logic [MW-1:0] MAX_METRIC_V = MW'(MAX_METRIC);

   // Elaboration-time parameter checks
   if (SOFT_W < 2 || SOFT_W > 8) begin : g_bad_soft
      $error("soft_bmu: SOFT_W must lie in 2..8");
   end
   if (NUM_SYM < 1 || NUM_SYM > 4) begin : g_bad_nsym
      $error("soft_bmu: NUM_SYM must lie in 1..4");
   end
   if (MW < metric_bits(SOFT_W, NUM_SYM)) begin : g_bad_mw
      $error("soft_bmu: MW cannot hold the largest summed metric");
   end

   logic [NUM_SYM-1:0][TERM_W-1:0] dz;
   logic [NUM_SYM-1:0][TERM_W-1:0] d1;
   logic [HYP-1:0][MW-1:0]         sum_d;
   logic [HYP-1:0][MW-1:0]         metric_q;

   for (genvar k = 0; k < NUM_SYM; k++) begin : g_sym
      sbmu_sym_term #(
         .SOFT_W (SOFT_W),
         .TERM_W (TERM_W)
      ) u_term (
         .soft_i      (soft_i[k*SOFT_W +: SOFT_W]),
         .keep_i      (keep_i[k]),
         .dist_zero_o (dz[k]),
         .dist_one_o  (d1[k])
      );
   end

   sbmu_hyp_sum #(
      .NUM_SYM (NUM_SYM),
      .TERM_W  (TERM_W),
      .MW      (MW)
   ) u_sum (
      .dz_i  (dz),
      .d1_i  (d1),
      .sum_o (sum_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         metric_q  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) metric_q <= sum_d;
      end
   end

   assign metric_o = metric_q;

   // ---------------- assertions ----------------
   logic [NUM_SYM-1:0] hard_v;
   logic [HYP-1:0]     zero_flag;
   for (genvar k = 0; k < NUM_SYM; k++) begin : g_hard
      assign hard_v[k] = (soft_i[k*SOFT_W +: SOFT_W] == SOFT_W'(0)) ||
                         (soft_i[k*SOFT_W +: SOFT_W] == SOFT_W'(PEAK));
   end
   for (genvar h = 0; h < HYP; h++) begin : g_zero
      assign zero_flag[h] = (metric_o[h*MW +: MW] == '0);

      p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
         metric_o[h*MW +: MW] <= MAX_METRIC_V);
   end

   p_valid_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_valid_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(metric_o));

   p_masked_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && keep_i == '0) |=> (metric_o == '0));

   p_hard_unique_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (&keep_i) && (&hard_v)) |=> ($countones(zero_flag) == 1));

endmodule

// File: tb/soft_bmu_bench.sv
module soft_bmu_bench;
   localparam int SW = 3;
   localparam int NS = 2;
   localparam int MW = 7;
   localparam int HY = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic [NS*SW-1:0]  soft_i = '0;
   logic [NS-1:0]     keep_i = '0;
   logic              out_valid;
   logic [HY*MW-1:0]  metric_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   typedef struct {
      logic           v;
      logic           hard;
      logic [HY*MW-1:0] m;
      string          tag;
   } exp_t;

   exp_t exp_q[$];
   logic [HY*MW-1:0] last_m = '0;

   always #2 clk = ~clk;   // 250 MHz

   soft_bmu u_soft_bmu (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .soft_i    (soft_i),
      .keep_i    (keep_i),
      .out_valid (out_valid),
      .metric_o  (metric_o)
   );

   // Reference: sum of (s_k - 7*b_k)^2 over kept symbols (R1, R2, R4)
   function automatic logic [HY*MW-1:0] model(input int a, input int b,
                                               input logic [1:0] kp);
      logic [HY*MW-1:0] r;
      int s [2];
      s[0] = a; s[1] = b;
      r = '0;
      for (int h = 0; h < HY; h++) begin
         int sum;
         sum = 0;
         for (int k = 0; k < NS; k++) begin
            if (kp[k]) begin
               int d;
               d = s[k] - 7 * ((h >> k) & 1);
               sum += d * d;
            end
         end
         r[h*MW +: MW] = MW'(sum);
      end
      return r;
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [HY*MW-1:0] got, input logic [HY*MW-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
      end
   endtask

   // Driver: called right after a rising edge; occupies one cycle.
   task automatic step(input bit v, input int a, input int b,
                       input logic [1:0] kp, input string tag);
      exp_t e;
      #1;
      in_valid = v;
      soft_i   = {3'(b), 3'(a)};
      keep_i   = kp;
      @(posedge clk);
      if (v) last_m = model(a, b, kp);
      e.v    = v;
      e.hard = v && (kp == 2'b11) && (a == 0 || a == 7) && (b == 0 || b == 7);
      e.m    = last_m;
      e.tag  = tag;
      exp_q.push_back(e);
   endtask

   // Monitor: compares outputs against the scoreboard away from the edge.
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(out_valid == e.v, "R5", "out_valid",
                  {27'd0, out_valid}, {27'd0, e.v});
            check(metric_o == e.m, e.tag, "metrics", metric_o, e.m);
            if (e.hard) begin
               int z;
               z = 0;
               for (int h = 0; h < HY; h++)
                  if (metric_o[h*MW +: MW] == '0) z++;
               check(z == 1, "R8", "zero-metric count",
                     (HY*MW)'(z), (HY*MW)'(1));
            end
         end
      end
   end

   initial begin
      // R7: reset holds outputs at zero even with in_valid high
      in_valid = 1'b1;
      soft_i   = 6'b111_111;
      keep_i   = 2'b11;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check(out_valid == 1'b0, "R7", "out_valid in reset",
               {27'd0, out_valid}, '0);
         check(metric_o == '0, "R7", "metrics in reset", metric_o, '0);
      end
      @(posedge clk);
      #1;
      rst_n    = 1'b1;
      in_valid = 1'b0;
      @(posedge clk);

      // R1 R2: all soft pairs, both kept, idle cycles with new inputs (R6)
      for (int a = 0; a < 8; a++) begin
         for (int b = 0; b < 8; b++) begin
            step(1'b1, a, b, 2'b11, "R1 R2");
            if (((a * 8 + b) % 5) == 4)
               step(1'b0, 7 - b, a, 2'(a), "R6");
         end
      end

      // R4: one or both symbols absent
      for (int a = 0; a < 8; a += 3) begin
         for (int b = 0; b < 8; b += 2) begin
            step(1'b1, a, b, 2'b01, "R4");
            step(1'b1, a, b, 2'b10, "R4");
            step(1'b1, a, b, 2'b00, "R4");
         end
      end

      // R3: extreme pairs give the peak metric of 98
      step(1'b1, 7, 7, 2'b11, "R3");
      step(1'b1, 0, 0, 2'b11, "R3");
      step(1'b0, 3, 4, 2'b01, "R6");

      // R8: hard decisions, back to back
      step(1'b1, 0, 0, 2'b11, "R8");
      step(1'b1, 7, 0, 2'b11, "R8");
      step(1'b1, 0, 7, 2'b11, "R8");
      step(1'b1, 7, 7, 2'b11, "R8");

      // R6: long idle stretch with wandering inputs
      for (int i = 0; i < 6; i++) step(1'b0, i, 7 - i, 2'(i), "R6");
      step(1'b1, 5, 2, 2'b11, "R1 R2");
      step(1'b0, 0, 0, 2'b00, "R6");

      repeat (3) @(posedge clk);
      if (exp_q.size() != 0) begin
         fails++;
         $display("FAIL R5 scoreboard: %0d items left, expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   // Watchdog
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule